// File: doc/BRIEF.md
# Trapdoor-Unlocked Configuration Register Bank

This block sits on the I/O port of a legacy disk controller. Normally every access on the port goes straight through to the task-file registers. A small bank of timing and configuration registers is hidden behind those same offsets. The bank opens only after a fixed sequence of ordinary port accesses: two 16-bit reads at offset 1, then a byte write of 3 at offset 2. A single byte write of 0x83 at offset 2 closes it again.

While the bank is open, byte accesses at offset N reach configuration register N, and nothing is forwarded to the task file. The bank holds the following registers:

- read-cycle and write-cycle timing bytes, kept separately for device 0 and device 1;
- a control byte whose value 0x85 makes the programmed timings override the hardware strapping;
- a read-only strap bit that reports which of two bus clocks the board uses;
- a miscellaneous register that takes either the target device number or an address-setup code.

The timing engine that uses these values is outside this block.

Top module: `trapdoor_cfg_bank`

## Requirements
- R1: After reset the bank is closed (`cfg_open`=0) and `strap_ovr`=0. All four timing bytes read 0xFF, `addr_setup`=3 and `dev_sel`=0.
- R2: The bank opens at the clock edge of the key step, a byte write (`io_word`=0) of low byte 3 at offset 2. The key must directly follow two consecutive 16-bit reads (`io_word`=1) at offset 1.
- R3: Any access that is not the exact next step of the sequence returns the detector to idle. This includes a third read at offset 1, a byte-sized read, another offset, or a 16-bit or wrong-valued key write. Cycles without an access do not disturb the detector.
- R4: While closed, every access is forwarded: `tf_rd`/`tf_wr` follow `io_rd`/`io_wr`, and `io_rdata` equals `tf_rdata`. No configuration output changes.
- R5: While open, `tf_rd` and `tf_wr` stay low. A write at offset 0 or 1 loads the read-cycle or write-cycle timing byte of the selected device only. A read at the same offset returns that byte.
- R6: An open write at offset 6 with upper nibble 0 sets `dev_sel` to bit 0. An open write at offset 6 with a nonzero upper nibble sets `addr_setup` to bits 5:4 (codes 0x10, 0x20 and 0x30 give 1, 2 and 3). A read at offset 6 returns {2'b0, addr_setup, 3'b0, dev_sel}.
- R7: An open read at offset 5 returns `strap_clk` in bit 0 with all other bits 0. Writes to offset 5, such as 0xFF, change nothing.
- R8: `strap_ovr` is 1 exactly while the control byte at offset 3 holds 0x85. A read at offset 3 returns the control byte.
- R9: An open byte write of 0x83 at offset 2 closes the bank, and any other write at offset 2 is ignored. Closing keeps all programmed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 3 | Port offset |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_word | input | 1 | Access size: 1 = 16-bit, 0 = byte |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data (task file or configuration byte) |
| tf_addr | output | 3 | Offset forwarded to the task file |
| tf_word | output | 1 | Size forwarded to the task file |
| tf_wdata | output | 16 | Write data forwarded to the task file |
| tf_rd | output | 1 | Task-file read strobe, low while open |
| tf_wr | output | 1 | Task-file write strobe, low while open |
| tf_rdata | input | 16 | Task-file read data |
| strap_clk | input | 1 | Board clock-speed strap |
| cfg_open | output | 1 | Configuration bank is open |
| tim_rd | output | 16 | Read-cycle timing, device 1 in bits 15:8 |
| tim_wr | output | 16 | Write-cycle timing, device 1 in bits 15:8 |
| addr_setup | output | 2 | Shared address-setup code |
| dev_sel | output | 1 | Device the timing writes target |
| strap_ovr | output | 1 | Programmed timings override the strap |

## Verification
The bench inserts every combination of offset, direction and size between the two reads and before the key. A detector that only counts reads, ignores size, or lets a third read count would then open the bank at the wrong time. It sweeps the final step over all offsets, sizes and several data values. A loose key compare would open the bank on a 16-bit write or on a value other than 3. Timing writes are checked against a per-device model after each write, which catches a bank that writes both devices or ignores `dev_sel`. The bench also writes all 256 byte values except 0x83 to offset 2 while open, which catches a relock on any value that is not the close key.

// File: rtl/trapdoor_pkg.sv
package trapdoor_pkg;
   typedef enum logic [1:0] {SQ_IDLE, SQ_ONE, SQ_TWO, SQ_OPEN} seq_e;

   localparam int unsigned IDX_RDT   = 0;
   localparam int unsigned IDX_WRT   = 1;
   localparam int unsigned IDX_CTL   = 3;
   localparam int unsigned IDX_STRAP = 5;
   localparam int unsigned IDX_MISC  = 6;
endpackage

// File: rtl/td_unlock.sv
module td_unlock
   import trapdoor_pkg::*;
#(
   parameter int unsigned AW        = 3,
   parameter int unsigned TRIG_OFS  = 1,
   parameter int unsigned KEY_OFS   = 2,
   parameter logic [7:0]  OPEN_KEY  = 8'h03,
   parameter logic [7:0]  CLOSE_KEY = 8'h83
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          rd,
   input  logic          wr,
   input  logic          word,
   input  logic [7:0]    wbyte,
   output logic          open
);
   seq_e st_q, st_d;
   logic acc, trig_rd, key_wr, close_wr;

   assign acc      = rd | wr;
   assign trig_rd  = rd & word & (addr == AW'(TRIG_OFS));
   assign key_wr   = wr & ~word & (addr == AW'(KEY_OFS)) & (wbyte == OPEN_KEY);
   assign close_wr = wr & ~word & (addr == AW'(KEY_OFS)) & (wbyte == CLOSE_KEY);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SQ_IDLE: if (acc) st_d = trig_rd ? SQ_ONE : SQ_IDLE;
         SQ_ONE:  if (acc) st_d = trig_rd ? SQ_TWO : SQ_IDLE;
         SQ_TWO:  if (acc) st_d = key_wr  ? SQ_OPEN : SQ_IDLE;
         SQ_OPEN: if (close_wr) st_d = SQ_IDLE;
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= st_d;
   end

   assign open = (st_q == SQ_OPEN);

   assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_TWO) && key_wr |=> open);

   assert_stray_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != SQ_OPEN) && acc && !(trig_rd && st_q != SQ_TWO) && !(st_q == SQ_TWO && key_wr)
      |=> (st_q == SQ_IDLE));

   assert_close_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
      open && close_wr |=> !open);
endmodule

// File: rtl/td_regs.sv
module td_regs
   import trapdoor_pkg::*;
#(
   parameter int unsigned AW       = 3,
   parameter int unsigned TW       = 8,
   parameter int unsigned NDEV     = 2,
   parameter logic [TW-1:0] RST_TIM = '1,
   parameter logic [1:0]  RST_ASU  = 2'd3,
   parameter logic [TW-1:0] OVR_KEY = TW'(8'h85)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open,
   input  logic [AW-1:0]    addr,
   input  logic             wr,
   input  logic [TW-1:0]    wbyte,
   input  logic             strap,
   output logic [TW-1:0]    cfg_rd,
   output logic [NDEV*TW-1:0] tim_rd,
   output logic [NDEV*TW-1:0] tim_wr,
   output logic [1:0]       asu,
   output logic             dev,
   output logic             ovr
);
   localparam int unsigned DSW = (NDEV > 1) ? $clog2(NDEV) : 1;

   if (NDEV != 2) begin : g_bad_ndev
      $error("td_regs: device select is one bit, NDEV must be 2");
   end
   if (TW < 8) begin : g_bad_tw
      $error("td_regs: TW must be at least 8");
   end

   logic          wr_en;
   logic [TW-1:0] ctl_q;
   logic [1:0]    asu_q;
   logic          dev_q;
   logic [TW-1:0] rdt_sel, wrt_sel;

   assign wr_en = open & wr;

   for (genvar g = 0; g < NDEV; g++) begin : g_dev
      logic [TW-1:0] rdt_q, wrt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdt_q <= RST_TIM;
            wrt_q <= RST_TIM;
         end else if (wr_en && (DSW'(dev_q) == DSW'(g))) begin
            if (addr == AW'(IDX_RDT)) rdt_q <= wbyte;
            if (addr == AW'(IDX_WRT)) wrt_q <= wbyte;
         end
      end
      assign tim_rd[g*TW +: TW] = rdt_q;
      assign tim_wr[g*TW +: TW] = wrt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         asu_q <= RST_ASU;
         dev_q <= 1'b0;
      end else if (wr_en) begin
         if (addr == AW'(IDX_CTL)) ctl_q <= wbyte;
         if (addr == AW'(IDX_MISC)) begin
            if (wbyte[7:4] == 4'h0) dev_q <= wbyte[0];
            else                    asu_q <= wbyte[5:4];
         end
      end
   end

   assign rdt_sel = dev_q ? tim_rd[TW +: TW] : tim_rd[0 +: TW];
   assign wrt_sel = dev_q ? tim_wr[TW +: TW] : tim_wr[0 +: TW];

   always_comb begin
      cfg_rd = '0;
      case (addr)
         AW'(IDX_RDT):   cfg_rd = rdt_sel;
         AW'(IDX_WRT):   cfg_rd = wrt_sel;
         AW'(IDX_CTL):   cfg_rd = ctl_q;
         AW'(IDX_STRAP): cfg_rd = TW'(strap);
         AW'(IDX_MISC):  cfg_rd = TW'({asu_q, 3'b000, dev_q});
         default:        cfg_rd = '0;
      endcase
   end

   assign asu = asu_q;
   assign dev = dev_q;
   assign ovr = (ctl_q == OVR_KEY);

   assert_closed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !open |=> $stable(tim_rd) && $stable(tim_wr) && $stable(asu) && $stable(dev) && $stable(ovr));

   assert_setup_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (addr == AW'(IDX_MISC)) && (wbyte[7:4] != 4'h0) |=> (asu == $past(wbyte[5:4])));

   assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (addr == AW'(IDX_CTL)) && (wbyte == OVR_KEY) |=> ovr);
endmodule

// File: rtl/trapdoor_cfg_bank.sv
module trapdoor_cfg_bank
   import trapdoor_pkg::*;
#(
   parameter int unsigned AW   = 3,
   parameter int unsigned DW   = 16,
   parameter int unsigned TW   = 8,
   parameter int unsigned NDEV = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      io_addr,
   input  logic               io_rd,
   input  logic               io_wr,
   input  logic               io_word,
   input  logic [DW-1:0]      io_wdata,
   output logic [DW-1:0]      io_rdata,
   output logic [AW-1:0]      tf_addr,
   output logic               tf_word,
   output logic [DW-1:0]      tf_wdata,
   output logic               tf_rd,
   output logic               tf_wr,
   input  logic [DW-1:0]      tf_rdata,
   input  logic               strap_clk,
   output logic               cfg_open,
   output logic [NDEV*TW-1:0] tim_rd,
   output logic [NDEV*TW-1:0] tim_wr,
   output logic [1:0]         addr_setup,
   output logic               dev_sel,
   output logic               strap_ovr
);
   if (AW < 3) begin : g_bad_aw
      $error("trapdoor_cfg_bank: AW must reach offset 6");
   end
   if (DW < TW) begin : g_bad_dw
      $error("trapdoor_cfg_bank: DW must hold a configuration byte");
   end

   logic [TW-1:0] cfg_rd;

   td_unlock #(.AW(AW)) u_unlock (
      .clk(clk), .rst_n(rst_n), .addr(io_addr), .rd(io_rd), .wr(io_wr),
      .word(io_word), .wbyte(io_wdata[7:0]), .open(cfg_open)
   );

   td_regs #(.AW(AW), .TW(TW), .NDEV(NDEV)) u_regs (
      .clk(clk), .rst_n(rst_n), .open(cfg_open), .addr(io_addr), .wr(io_wr),
      .wbyte(io_wdata[TW-1:0]), .strap(strap_clk), .cfg_rd(cfg_rd),
      .tim_rd(tim_rd), .tim_wr(tim_wr), .asu(addr_setup), .dev(dev_sel), .ovr(strap_ovr)
   );

   assign tf_addr  = io_addr;
   assign tf_word  = io_word;
   assign tf_wdata = io_wdata;
   assign tf_rd    = io_rd & ~cfg_open;
   assign tf_wr    = io_wr & ~cfg_open;

   if (DW > TW) begin : g_pad
      assign io_rdata = cfg_open ? {{(DW-TW){1'b0}}, cfg_rd} : tf_rdata;
   end else begin : g_flat
      assign io_rdata = cfg_open ? cfg_rd : tf_rdata;
   end
endmodule

// File: tb/sim_trapdoor_cfg_bank.sv
module sim_trapdoor_cfg_bank;
   logic clk = 0, rst_n = 0;
   logic [2:0] io_addr = 0;
   logic io_rd = 0, io_wr = 0, io_word = 0, strap_clk = 0;
   logic [15:0] io_wdata = 0, tf_rdata = 0;
   logic [15:0] io_rdata, tf_wdata, tim_rd, tim_wr;
   logic [2:0] tf_addr;
   logic tf_word, tf_rd, tf_wr, cfg_open, dev_sel, strap_ovr;
   logic [1:0] addr_setup;

   int n_chk = 0, n_bad = 0;
   logic [15:0] cap_rd;
   logic cap_tfr, cap_tfw;
   logic [7:0] m_rd [2], m_wr [2];

   always #2 clk = ~clk;

   trapdoor_cfg_bank u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_word(io_word), .io_wdata(io_wdata), .io_rdata(io_rdata), .tf_addr(tf_addr),
      .tf_word(tf_word), .tf_wdata(tf_wdata), .tf_rd(tf_rd), .tf_wr(tf_wr),
      .tf_rdata(tf_rdata), .strap_clk(strap_clk), .cfg_open(cfg_open),
      .tim_rd(tim_rd), .tim_wr(tim_wr), .addr_setup(addr_setup), .dev_sel(dev_sel),
      .strap_ovr(strap_ovr)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic acc(input logic [2:0] a, input logic r, input logic w,
                      input logic wd, input logic [15:0] d);
      @(negedge clk);
      io_addr = a; io_rd = r; io_wr = w; io_word = wd; io_wdata = d;
      tf_rdata = 16'hBE00 | 16'(a);
      #1;
      cap_rd = io_rdata; cap_tfr = tf_rd; cap_tfw = tf_wr;
      @(posedge clk);
      #1;
      io_rd = 0; io_wr = 0;
   endtask

   task automatic open_seq();
      acc(3'd1, 1, 0, 1, 0);
      acc(3'd1, 1, 0, 1, 0);
      acc(3'd2, 0, 1, 0, 16'h0003);
   endtask

   task automatic close_seq();
      acc(3'd2, 0, 1, 0, 16'h0083);
   endtask

   task automatic chk_tim(input string req);
      chk(req, tim_rd, {m_rd[1], m_rd[0]});
      chk(req, tim_wr, {m_wr[1], m_wr[0]});
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic exp_open;
      logic [15:0] vals [4];
      for (int i = 0; i < 2; i++) begin m_rd[i] = 8'hFF; m_wr[i] = 8'hFF; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      chk("R1 open", 16'(cfg_open), 0);
      chk("R1 ovr", 16'(strap_ovr), 0);
      chk_tim("R1 timing");
      chk("R1 asu", 16'(addr_setup), 3);
      chk("R1 dev", 16'(dev_sel), 0);

      // R4 closed: everything forwarded, nothing changes
      for (int a = 0; a < 8; a++) begin
         for (int s = 0; s < 2; s++) begin
            acc(3'(a), 0, 1, s[0], 16'h0085);
            chk("R4 tf_wr", 16'(cap_tfw), 1);
            acc(3'(a), 1, 0, s[0], 0);
            chk("R4 tf_rd", 16'(cap_tfr), 1);
            chk("R4 rdata", cap_rd, 16'hBE00 | 16'(a));
         end
      end
      chk("R4 open", 16'(cfg_open), 0);
      chk("R4 ovr", 16'(strap_ovr), 0);
      chk("R4 asu", 16'(addr_setup), 3);
      chk_tim("R4 timing");

      // R2 basic open, key write itself is still forwarded
      open_seq();
      chk("R2 key forwarded", 16'(cap_tfw), 1);
      chk("R2 open", 16'(cfg_open), 1);
      close_seq();
      chk("R2 closed again", 16'(cfg_open), 0);
      // idle cycles between steps are harmless
      acc(3'd1, 1, 0, 1, 0);
      repeat (3) @(posedge clk);
      acc(3'd1, 1, 0, 1, 0);
      repeat (2) @(posedge clk);
      acc(3'd2, 0, 1, 0, 16'h0003);
      chk("R3 idle gaps", 16'(cfg_open), 1);
      close_seq();

      // R3 an extra access between the two reads breaks the sequence
      for (int a = 0; a < 8; a++) begin
         for (int k = 0; k < 4; k++) begin
            acc(3'd1, 1, 0, 1, 0);
            acc(3'(a), ~k[1], k[1], k[0], 16'h0003);
            acc(3'd1, 1, 0, 1, 0);
            acc(3'd2, 0, 1, 0, 16'h0003);
            chk("R3 interposed", 16'(cfg_open), 0);
            if (cfg_open) close_seq();
         end
      end

      // R2/R3 sweep of the final step
      vals[0] = 16'h0003; vals[1] = 16'h0083; vals[2] = 16'h0002; vals[3] = 16'h0007;
      for (int a = 0; a < 8; a++) begin
         for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 4; v++) begin
               acc(3'd1, 1, 0, 1, 0);
               acc(3'd1, 1, 0, 1, 0);
               acc(3'(a), 0, 1, s[0], vals[v]);
               exp_open = (a == 2) && (s == 0) && (v == 0);
               chk(exp_open ? "R2 final step" : "R3 final step", 16'(cfg_open), 16'(exp_open));
               if (cfg_open) close_seq();
            end
         end
      end

      // R5 per-device timing writes
      open_seq();
      for (int d = 0; d < 2; d++) begin
         acc(3'd6, 0, 1, 0, 16'(d));
         chk("R6 dev", 16'(dev_sel), 16'(d));
         for (int v = 0; v < 6; v++) begin
            logic [7:0] x;
            x = 8'(v * 37 + d * 11 + 5);
            acc(3'd0, 0, 1, 0, 16'(x));
            chk("R5 no tf_wr", 16'(cap_tfw), 0);
            m_rd[d] = x;
            acc(3'd1, 0, 1, 0, 16'(x ^ 8'h5A));
            m_wr[d] = x ^ 8'h5A;
            chk_tim("R5 timing");
            acc(3'd0, 1, 0, 0, 0);
            chk("R5 no tf_rd", 16'(cap_tfr), 0);
            chk("R5 read rdt", cap_rd, 16'(m_rd[d]));
            acc(3'd1, 1, 0, 0, 0);
            chk("R5 read wrt", cap_rd, 16'(m_wr[d]));
         end
      end

      // R6 address-setup codes
      for (int c = 3; c >= 1; c--) begin
         acc(3'd6, 0, 1, 0, 16'(c * 16));
         chk("R6 asu", 16'(addr_setup), 16'(c));
         chk("R6 dev kept", 16'(dev_sel), 1);
         acc(3'd6, 1, 0, 0, 0);
         chk("R6 misc read", cap_rd, 16'(c * 16 + 1));
      end
      acc(3'd6, 0, 1, 0, 16'h0000);
      chk("R6 dev to 0", 16'(dev_sel), 0);
      chk("R6 asu kept", 16'(addr_setup), 1);

      // R7 strap bit and ignored writes
      for (int s = 0; s < 2; s++) begin
         strap_clk = s[0];
         acc(3'd5, 0, 1, 0, 16'h00FF);
         acc(3'd5, 1, 0, 1, 0);
         chk("R7 strap", cap_rd, 16'(s));
         chk_tim("R7 timing");
         chk("R7 asu", 16'(addr_setup), 1);
      end

      // R8 control byte
      acc(3'd3, 0, 1, 0, 16'h0085);
      chk("R8 ovr on", 16'(strap_ovr), 1);
      acc(3'd3, 1, 0, 0, 0);
      chk("R8 read", cap_rd, 16'h0085);
      acc(3'd3, 0, 1, 0, 16'h0084);
      chk("R8 ovr off", 16'(strap_ovr), 0);
      acc(3'd3, 0, 1, 0, 16'h0085);
      chk("R8 ovr again", 16'(strap_ovr), 1);

      // R9 only the byte close key relocks
      for (int v = 0; v < 256; v++) begin
         if (v != 8'h83) begin
            acc(3'd2, 0, 1, 0, 16'(v));
            chk("R9 stay open", 16'(cfg_open), 1);
         end
      end
      acc(3'd2, 0, 1, 1, 16'h0083);
      chk("R9 word write", 16'(cfg_open), 1);
      close_seq();
      chk("R9 closed", 16'(cfg_open), 0);
      acc(3'd0, 1, 0, 0, 0);
      chk("R9 tf read", cap_rd, 16'hBE00);
      chk("R9 ovr kept", 16'(strap_ovr), 1);
      chk_tim("R9 timing kept");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule